// File: doc/BRIEF.md
# Write-Back Set-Associative Word Cache

This block is a data cache for 32-bit words that sits between a single requester and a word-addressed main memory. The number of sets, the ways in each set and the words in each block are parameters, so one line per set gives a direct-mapped cache. Each line carries a valid bit, a tag, an access timestamp, a dirty flag for every word and the block data. A read or a write that misses first brings the whole block in from memory, so write misses allocate.

Replacement is least-recently-used, kept by timestamps. The cache counts the read and write requests it receives. Each time a line is filled or accessed, it records the current count in that line. When a set has no free line, the valid line with the smallest recorded count is evicted. Before the replacing block is fetched, only the words of the victim that were changed are written back.

Two maintenance operations walk every line in the cache. Flush writes back all changed words and then leaves every line invalid. Clean writes back all changed words, clears every dirty flag and leaves the lines valid. Four counters report total reads, read hits, total writes and write hits.

Top module: `wb_cache`

## Requirements
- R1: After a synchronous active-high reset, req_ready is high, resp_valid and mem_req are low, all four counters read zero and every line is invalid, so the first read misses.
- R2: The operation code on req_op is 0 for read, 1 for write, 2 for flush and 3 for clean. A request is taken on a clock edge where req_valid and req_ready are both high. From the following cycle, req_ready stays low until the operation completes. At completion resp_valid pulses high for one cycle. resp_rdata then holds the word read, the word written, or zero for a maintenance operation.
- R3: A read hit returns the cached word and causes no memory traffic.
- R4: A miss fetches the whole block with one memory read per word. The reads start at the block base and run through the word offsets in ascending order. The addressed word is served only after the last of these reads.
- R5: A write miss allocates. The block is fetched, then the word is updated in the cache only, and memory receives the new value only when that word is written back later.
- R6: The cache counts its accepted read and write requests. A filled or accessed line records the current count. When the target set is full, the valid line with the lowest recorded count is evicted.
- R7: When several lines in the target set are invalid, the one with the lowest way number is filled.
- R8: An eviction writes back only the victim's modified words, in ascending word order. All of these writes come before the first fill read of the new block.
- R9: Flush writes every modified word in the cache back to memory and makes every line invalid, so the next access to any address misses.
- R10: Clean writes every modified word back to memory and leaves the lines valid and unmodified. A following access still hits, and a second clean writes nothing.
- R11: rd_total and wr_total count accepted reads and writes. rd_hits and wr_hits count those that hit. Maintenance operations change none of the four counters.
- R12: While mem_req is high and mem_ack has not arrived, mem_req, mem_we, mem_addr and mem_wdata stay unchanged. A memory read returns its data on mem_rdata in the cycle mem_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 flush, 3 clean |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read word, written word, or zero |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| rd_total | output | 32 | Reads accepted |
| rd_hits | output | 32 | Reads that hit |
| wr_total | output | 32 | Writes accepted |
| wr_hits | output | 32 | Writes that hit |

## Verification
The bench builds the cache with its default parameters: four sets, two ways and four words per block. With these sizes a short address sequence can fill one set and force evictions in it, so invalid-way preference, timestamp ordering and dirty-word write-back all show up within a few requests. The small number of sets also keeps a flush or clean walk short. This lets the bench compare the memory traffic of each maintenance operation word by word against a memory model that acknowledges after a delay.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FLUSH = 2'd2,
    OP_CLEAN = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_ACC
  } state_e;

endpackage

// File: rtl/wbc_tag_match.sv
module wbc_tag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 28,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            match_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign match_o[g] = valid_i[g] && (tags_i[g] == tag_i);
    end
  endgenerate

  always_comb begin
    hit_o = |match_o;
    way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match_o[i]) way_o = WAY_W'(i);
    end
  end

endmodule

// File: rtl/wbc_victim.sv
module wbc_victim #(
  parameter int WAYS  = 2,
  parameter int TS_W  = 16,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]           valid_i,
  input  logic [WAYS-1:0][TS_W-1:0] ts_i,
  output logic [WAY_W-1:0]          way_o
);

  logic            have_free;
  logic [TS_W-1:0] oldest;

  always_comb begin
    have_free = 1'b0;
    way_o     = '0;
    oldest    = ts_i[0];
    for (int i = 0; i < WAYS; i++) begin
      if (!valid_i[i] && !have_free) begin
        have_free = 1'b1;
        way_o     = WAY_W'(i);
      end
    end
    if (!have_free) begin
      for (int i = 1; i < WAYS; i++) begin
        if (ts_i[i] < oldest) begin
          oldest = ts_i[i];
          way_o  = WAY_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/wbc_data_ram.sv
module wbc_data_ram #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int WORDS  = 4,
  parameter int TS_W   = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  rd_total,
  output logic [CNT_W-1:0]  rd_hits,
  output logic [CNT_W-1:0]  wr_total,
  output logic [CNT_W-1:0]  wr_hits
);

  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int RAM_AW = IDX_W + WAY_W + OFF_W;
  localparam logic [OFF_W-1:0] WORD_LAST = OFF_W'(WORDS - 1);
  localparam logic [IDX_W-1:0] SET_LAST  = IDX_W'(SETS - 1);
  localparam logic [WAY_W-1:0] WAY_LAST  = WAY_W'(WAYS - 1);

  state_e            state;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  set_q;
  logic [WAY_W-1:0]  way_q;
  logic [OFF_W-1:0]  wi_q;
  logic [TS_W-1:0]   stamp;

  logic [SETS-1:0][WAYS-1:0]             valid_arr;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_arr;
  logic [SETS-1:0][WAYS-1:0][TS_W-1:0]   ts_arr;
  logic [SETS-1:0][WAYS-1:0][WORDS-1:0]  dirty_arr;

  logic [OFF_W-1:0] a_off;
  logic [TAG_W-1:0] a_tag;
  assign a_off = addr_q[OFF_W-1:0];
  assign a_tag = addr_q[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]  match_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim_way;

  wbc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .valid_i (valid_arr[set_q]),
    .tags_i  (tag_arr[set_q]),
    .tag_i   (a_tag),
    .match_o (match_vec),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  wbc_victim #(.WAYS(WAYS), .TS_W(TS_W), .WAY_W(WAY_W)) u_victim (
    .valid_i (valid_arr[set_q]),
    .ts_i    (ts_arr[set_q]),
    .way_o   (victim_way)
  );

  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr;
  logic [RAM_AW-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  wbc_data_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  logic line_valid;
  logic word_dirty;
  logic line_last;
  logic wb_issue;
  logic wb_step;
  logic wb_line_done;
  logic is_maint;

  assign line_valid = valid_arr[set_q][way_q];
  assign word_dirty = dirty_arr[set_q][way_q][wi_q];
  assign line_last  = (set_q == SET_LAST) && (way_q == WAY_LAST);
  assign is_maint   = (op_q == OP_FLUSH) || (op_q == OP_CLEAN);
  assign req_ready  = (state == ST_IDLE);

  // write-back walk over the words of the line at (set_q, way_q)
  assign wb_issue     = (state == ST_WB) && !mem_req && line_valid && word_dirty;
  assign wb_step      = (state == ST_WB) &&
                        ((mem_req && mem_ack) || (!mem_req && !(line_valid && word_dirty)));
  assign wb_line_done = (state == ST_WB) &&
                        ((!line_valid && !mem_req) || (wb_step && (wi_q == WORD_LAST)));

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {set_q, way_q, wi_q};
    ram_wdata = mem_rdata;
    if (state == ST_FILL && mem_req && mem_ack) begin
      ram_we = 1'b1;
    end else if (state == ST_ACC && op_q == OP_WRITE) begin
      ram_we    = 1'b1;
      ram_waddr = {set_q, way_q, a_off};
      ram_wdata = wdata_q;
    end
    ram_raddr = (state == ST_ACC) ? {set_q, way_q, a_off} : {set_q, way_q, wi_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= OP_READ;
      addr_q     <= '0;
      wdata_q    <= '0;
      set_q      <= '0;
      way_q      <= '0;
      wi_q       <= '0;
      stamp      <= '0;
      valid_arr  <= '0;
      tag_arr    <= '0;
      ts_arr     <= '0;
      dirty_arr  <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rd_total   <= '0;
      rd_hits    <= '0;
      wr_total   <= '0;
      wr_hits    <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= op_e'(req_op);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wi_q    <= '0;
            if (req_op == OP_FLUSH || req_op == OP_CLEAN) begin
              set_q <= '0;
              way_q <= '0;
              state <= ST_WB;
            end else begin
              set_q <= req_addr[OFF_W +: IDX_W];
              stamp <= stamp + TS_W'(1);
              state <= ST_LOOK;
            end
          end
        end
        ST_LOOK: begin
          if (op_q == OP_WRITE) begin
            wr_total <= wr_total + CNT_W'(1);
            if (hit) wr_hits <= wr_hits + CNT_W'(1);
          end else begin
            rd_total <= rd_total + CNT_W'(1);
            if (hit) rd_hits <= rd_hits + CNT_W'(1);
          end
          if (hit) begin
            way_q <= hit_way;
            state <= ST_ACC;
          end else begin
            way_q <= victim_way;
            wi_q  <= '0;
            state <= ST_WB;
          end
        end
        ST_WB: begin
          if (wb_issue) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {tag_arr[set_q][way_q], set_q, wi_q};
            mem_wdata <= ram_rdata;
          end
          if (mem_req && mem_ack) mem_req <= 1'b0;
          if (wb_line_done) begin
            dirty_arr[set_q][way_q] <= '0;
            wi_q <= '0;
            if (is_maint) begin
              if (op_q == OP_FLUSH) valid_arr[set_q][way_q] <= 1'b0;
              if (line_last) begin
                state      <= ST_IDLE;
                resp_valid <= 1'b1;
                resp_rdata <= '0;
              end else if (way_q == WAY_LAST) begin
                way_q <= '0;
                set_q <= set_q + IDX_W'(1);
              end else begin
                way_q <= way_q + WAY_W'(1);
              end
            end else begin
              state <= ST_FILL;
            end
          end else if (wb_step) begin
            wi_q <= wi_q + OFF_W'(1);
          end
        end
        ST_FILL: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {a_tag, set_q, wi_q};
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (wi_q == WORD_LAST) begin
              valid_arr[set_q][way_q] <= 1'b1;
              tag_arr[set_q][way_q]   <= a_tag;
              wi_q  <= '0;
              state <= ST_ACC;
            end else begin
              wi_q <= wi_q + OFF_W'(1);
            end
          end
        end
        ST_ACC: begin
          ts_arr[set_q][way_q] <= stamp;
          if (op_q == OP_WRITE) begin
            dirty_arr[set_q][way_q][a_off] <= 1'b1;
            resp_rdata <= wdata_q;
          end else begin
            resp_rdata <= ram_rdata;
          end
          resp_valid <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK) |-> $onehot0(match_vec)); // R3

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R2

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R12

  AST_FILL_READS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (state == ST_FILL)); // R4

  AST_WB_DIRTY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (state == ST_WB && word_dirty)); // R8

  AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (rd_hits <= rd_total) && (wr_hits <= wr_total)); // R11

  AST_STAMP_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stamp >= $past(stamp))); // R6

endmodule

// File: tb/wb_cache_test.sv
module wb_cache_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic [31:0] rd_total, rd_hits, wr_total, wr_hits;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wb_cache uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rd_total(rd_total), .rd_hits(rd_hits), .wr_total(wr_total), .wr_hits(wr_hits)
  );

  // memory model: 256 words, acknowledges two cycles after a request appears
  logic [31:0] mem [0:255];
  logic [31:0] log_addr [0:255];
  logic        log_we [0:255];
  int          log_n = 0;
  logic [1:0]  dly;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      dly       <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + i;
    end else if (mem_req && !mem_ack) begin
      if (dly == 2'd1) begin
        mem_ack <= 1'b1;
        dly     <= '0;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[7:0]];
        log_we[log_n]   <= mem_we;
        log_addr[log_n] <= mem_addr;
        log_n <= log_n + 1;
      end else begin
        dly <= dly + 2'd1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one operation; report response word and memory traffic it caused
  task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int nr, output int nw,
                        output int bad_order, output int bad_fill, output logic [31:0] first_wb);
    int s;
    int seen_rd;
    while (!req_ready) @(negedge clk);
    s = log_n;
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    rd = resp_rdata;
    @(negedge clk);
    nr = 0; nw = 0; bad_order = 0; bad_fill = 0; seen_rd = 0; first_wb = 32'hFFFF_FFFF;
    for (int k = s; k < log_n; k++) begin
      if (log_we[k]) begin
        if (nw == 0) first_wb = log_addr[k];
        nw++;
        if (seen_rd != 0) bad_order++;
      end else begin
        if (log_addr[k] !== ((addr & 32'hFFFF_FFFC) + nr)) bad_fill++;
        nr++;
        seen_rd = 1;
      end
    end
  endtask

  // op, addr[7:0], wdata, expected response, fill reads, write-backs
  localparam int NV = 9;
  localparam logic [81:0] VEC [0:NV-1] = '{
    {2'd0, 8'h01, 32'h0000_0000, 32'hA000_0001, 4'd4, 4'd0},
    {2'd0, 8'h02, 32'h0000_0000, 32'hA000_0002, 4'd0, 4'd0},
    {2'd1, 8'h03, 32'h1111_1111, 32'h1111_1111, 4'd0, 4'd0},
    {2'd0, 8'h11, 32'h0000_0000, 32'hA000_0011, 4'd4, 4'd0},
    {2'd0, 8'h00, 32'h0000_0000, 32'hA000_0000, 4'd0, 4'd0},
    {2'd0, 8'h21, 32'h0000_0000, 32'hA000_0021, 4'd4, 4'd0},
    {2'd1, 8'h12, 32'h2222_2222, 32'h2222_2222, 4'd4, 4'd1},
    {2'd0, 8'h03, 32'h0000_0000, 32'h1111_1111, 4'd4, 4'd0},
    {2'd0, 8'h12, 32'h0000_0000, 32'h2222_2222, 4'd0, 4'd0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired, actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, fwb;
    int nr, nw, bo, bf;
    rst = 1'b1; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 counters", rd_total | rd_hits | wr_total | wr_hits, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      v = VEC[i];
      run_op(v[81:80], {24'd0, v[79:72]}, v[71:40], rd, nr, nw, bo, bf, fwb);
      chk(v[81:80] == 2'd1 ? "R5 write response" : "R3 read data", rd, v[39:8]);
      chk("R4 fill reads", nr, {28'd0, v[7:4]});
      chk("R8 write-backs", nw, {28'd0, v[3:0]});
      chk("R8 write-back before fill", bo, 32'd0);
      chk("R4 fill address order", bf, 32'd0);
      if (i == 6) chk("R6 evicted dirty word address", fwb, 32'h0000_0003);
    end
    // R7 (step 3 filled the free way, step 5 then evicted by timestamp without write-back)
    chk("R11 rd_total", rd_total, 32'd7);
    chk("R11 rd_hits", rd_hits, 32'd3);
    chk("R11 wr_total", wr_total, 32'd2);
    chk("R11 wr_hits", wr_hits, 32'd1);

    // R10 clean writes the dirty word, keeps the line
    run_op(2'd3, 32'h0, 32'h0, rd, nr, nw, bo, bf, fwb);
    chk("R10 clean write-backs", nw, 32'd1);
    chk("R10 clean address", fwb, 32'h0000_0012);
    chk("R10 memory updated", mem[8'h12], 32'h2222_2222);
    chk("R2 maintenance response", rd, 32'd0);
    run_op(2'd0, 32'h12, 32'h0, rd, nr, nw, bo, bf, fwb);
    chk("R10 still hits", nr + nw, 32'd0);
    chk("R10 data", rd, 32'h2222_2222);
    run_op(2'd3, 32'h0, 32'h0, rd, nr, nw, bo, bf, fwb);
    chk("R10 second clean idle", nw, 32'd0);

    // R5 write miss allocates, memory untouched until written back
    run_op(2'd1, 32'h05, 32'h3333_3333, rd, nr, nw, bo, bf, fwb);
    chk("R5 write miss fill", nr, 32'd4);
    chk("R5 memory not yet written", mem[8'h05], 32'hA000_0005);

    // R9 flush
    run_op(2'd2, 32'h0, 32'h0, rd, nr, nw, bo, bf, fwb);
    chk("R9 flush write-backs", nw, 32'd1);
    chk("R9 flush address", fwb, 32'h0000_0005);
    chk("R9 memory updated", mem[8'h05], 32'h3333_3333);
    run_op(2'd0, 32'h12, 32'h0, rd, nr, nw, bo, bf, fwb);
    chk("R9 miss after flush", nr, 32'd4);
    chk("R9 data after flush", rd, 32'h2222_2222);
    run_op(2'd0, 32'h05, 32'h0, rd, nr, nw, bo, bf, fwb);
    chk("R9 second miss after flush", nr, 32'd4);
    chk("R9 written value", rd, 32'h3333_3333);

    chk("R11 rd_total final", rd_total, 32'd10);
    chk("R11 rd_hits final", rd_hits, 32'd4);
    chk("R11 wr_total final", wr_total, 32'd3);
    chk("R11 wr_hits final", wr_hits, 32'd1);
    chk("R12 memory transactions", log_n, 32'd35);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule